// File: doc/BRIEF.md
# MDIO Clause-22/45 Management Controller

This block is a register-driven MDIO master. Software fills a data register and then writes an access register whose low bit starts one management frame toward an external PHY. The block generates MDC from the system clock at one of five selectable rates. It drives MDIO through a separate output and output enable, so that a tri-state pad can sit outside it, and it samples the pad's input path when read data comes back.

One access-register bit chooses the framing. Clause 22 frames carry a PHY address and a register index. Clause 45 frames carry a PHY address and a device address, with a 2-bit command: set address, write, read, or read with post-increment. The command code is remapped to the opcode that goes on the wire. A Clause 45 register read is issued by software as two commands: first an address frame, then a read frame. The busy flag clears between the two.

Software polls the busy bit. While a frame runs, register writes are dropped. When a read frame completes, the captured 16-bit value is in the data register.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The access register is at offset 0x120 and reads back as follows: rate in [18:16], PHY address in [15:11], register index or device address in [10:6], Clause 45 select in [3], command in [2:1] and busy in [0]. All other bits read 0. The data register is at 0x124 and reads back its 32 stored bits. Any other offset reads 0.
- R2: While idle, writing the access register with bit 0 set stores the fields and starts exactly one 64-bit frame. Busy reads 1 from the next cycle until the frame ends, then 0. Writing with bit 0 clear only stores the fields and starts no frame.
- R3: While busy, writes to either register are ignored. The running frame, the stored fields, the data register and the number of frames all stay unchanged.
- R4: A frame is sent MSB first in this order: 32 ones, start (01 for Clause 22, 00 for Clause 45), opcode, 5-bit PHY address, 5-bit register/device address, 2 turnaround bits, 16 data bits.
- R5: The Clause 45 command maps to the wire opcode as 00→00 (address), 01→01 (write), 10→11 (read) and 11→10 (read-increment). In Clause 22, bit 1 = 1 sends opcode 01 (write) and bit 1 = 0 sends opcode 10 (read).
- R6: Write and address frames drive all 64 bits. Turnaround is 10 and the data field is the low 16 bits of the data register.
- R7: Read frames (both Clause 45 reads and Clause 22 reads) release MDIO for the last 18 bits. They sample the input at the MDC rising edge of each of the 16 data bits, MSB first. When busy clears, the data register holds the result in [15:0] with [31:16] zero.
- R8: MDC has a period of 2·⌊SYS_CLK_KHZ/(2·f)⌋ system clocks. With the default 100 MHz system clock, rate codes 0, 1, 2, 3 and 4 (2.5, 5, 12.5, 25 and 1.25 MHz) give 40, 20, 8, 4 and 80 clocks. Codes 5 to 7 act as code 4. MDC only toggles while busy.
- R9: While idle, MDC is low and the MDIO output enable is low. MDIO output and output enable change only while MDC is low, so they are stable at every MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Register write strobe |
| csrAddr | input | ADDR_W | Register offset for read and write |
| csrWrData | input | 32 | Register write data |
| csrRdData | output | 32 | Register read data for csrAddr (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdioO | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable, 1 drives the pad |
| mdioI | input | 1 | MDIO input sampled from the pad |

## Verification
Some properties are checked on every cycle: MDC is quiet and MDIO is released when idle, MDIO holds still while MDC is high, MDC never rises outside a frame, the stored fields do not change during a frame, and the output enable is released during the turnaround and data bits of read frames. Only the bench scenarios can show the remaining behaviour. These are the bit-exact frame contents and opcode remapping for every command and both clause modes, the measured MDC period for each rate code including the aliased ones, the captured read value, and that a write arriving mid-frame leaves both registers and the frame count untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int DATA_BITS  = 16;
  localparam int TA_BITS    = 2;
  localparam int DRIVE_RD   = FRAME_BITS - DATA_BITS - TA_BITS;
  localparam int SAMPLE_AT  = FRAME_BITS - DATA_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic [2:0] rate;
    logic [4:0] phy;
    logic [4:0] regad;
    logic       cl45;
    logic [1:0] cmd;
  } accFields_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic done;
  } mdioStrobe_t;

  function automatic logic isReadCmd(input logic cl45, input logic [1:0] cmd);
    return cl45 ? cmd[1] : ~cmd[0];
  endfunction

  function automatic logic [1:0] wireOp(input logic cl45, input logic [1:0] cmd);
    logic [1:0] op;
    if (cl45) begin
      case (cmd)
        2'b00:   op = 2'b00;
        2'b01:   op = 2'b01;
        2'b10:   op = 2'b11;
        default: op = 2'b10;
      endcase
    end else begin
      op = cmd[0] ? 2'b01 : 2'b10;
    end
    return op;
  endfunction
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int SYS_CLK_KHZ = 100000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accWr,
  input  logic                 wrGo,
  input  accFields_t           wrFields,
  output logic                 busy,
  output accFields_t           fields,
  output mdioStrobe_t          strb,
  output logic [IDX_W-1:0]     bitIdx,
  output logic                 isRead,
  output logic                 mdc
);
  function automatic int halfOf(input int khz);
    int h;
    h = SYS_CLK_KHZ / (2 * khz);
    return (h < 1) ? 1 : h;
  endfunction

  localparam int HALF_2M5  = halfOf(2500);
  localparam int HALF_5M   = halfOf(5000);
  localparam int HALF_12M5 = halfOf(12500);
  localparam int HALF_25M  = halfOf(25000);
  localparam int HALF_1M25 = halfOf(1250);
  localparam int DIV_W     = $clog2(HALF_1M25 + 1);

  logic [DIV_W-1:0] divCnt, halfDiv, halfSel;
  logic             mdcQ, start, tick, rise, fall, lastBit;
  logic [IDX_W-1:0] bitCnt;

  always_comb begin
    case (wrFields.rate)
      3'd0:    halfSel = DIV_W'(HALF_2M5);
      3'd1:    halfSel = DIV_W'(HALF_5M);
      3'd2:    halfSel = DIV_W'(HALF_12M5);
      3'd3:    halfSel = DIV_W'(HALF_25M);
      default: halfSel = DIV_W'(HALF_1M25);
    endcase
  end

  assign start   = accWr && !busy && wrGo;
  assign tick    = busy && (divCnt == halfDiv - DIV_W'(1));
  assign rise    = tick && !mdcQ;
  assign fall    = tick && mdcQ;
  assign lastBit = (bitCnt == IDX_W'(FRAME_BITS - 1));
  assign isRead  = isReadCmd(fields.cl45, fields.cmd);

  assign strb.load   = start;
  assign strb.shift  = fall && !lastBit;
  assign strb.sample = rise && isRead && (bitCnt >= IDX_W'(SAMPLE_AT));
  assign strb.done   = fall && lastBit;

  assign bitIdx = bitCnt;
  assign mdc    = mdcQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      fields  <= '0;
      divCnt  <= '0;
      halfDiv <= DIV_W'(1);
      mdcQ    <= 1'b0;
      bitCnt  <= '0;
    end else begin
      if (accWr && !busy) fields <= wrFields;
      if (start) begin
        busy    <= 1'b1;
        halfDiv <= halfSel;
        divCnt  <= '0;
        mdcQ    <= 1'b0;
        bitCnt  <= '0;
      end else if (busy) begin
        divCnt <= tick ? '0 : divCnt + DIV_W'(1);
        if (tick)        mdcQ   <= ~mdcQ;
        if (strb.shift)  bitCnt <= bitCnt + IDX_W'(1);
        if (strb.done)   busy   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mdioStrobe_t strb,
  input  logic [4:0]  ldPhy,
  input  logic [4:0]  ldReg,
  input  logic        ldCl45,
  input  logic [1:0]  ldCmd,
  input  logic        dataWr,
  input  logic [31:0] wrData,
  input  logic        mdioI,
  output logic        mdioO,
  output logic        mdioOe,
  output logic [31:0] dataReg
);
  logic [FRAME_BITS-1:0] frameSr, oeSr, frameNew, oeNew;
  logic [DATA_BITS-1:0]  capSr;
  logic                  readQ, loadRead;

  assign loadRead = isReadCmd(ldCl45, ldCmd);

  always_comb begin
    frameNew = {{PRE_BITS{1'b1}},
                ldCl45 ? 2'b00 : 2'b01,
                wireOp(ldCl45, ldCmd),
                ldPhy, ldReg,
                loadRead ? 2'b11 : 2'b10,
                loadRead ? {DATA_BITS{1'b1}} : dataReg[DATA_BITS-1:0]};
    oeNew = loadRead ? {{DRIVE_RD{1'b1}}, {(FRAME_BITS - DRIVE_RD){1'b0}}}
                     : {FRAME_BITS{1'b1}};
  end

  assign mdioO  = frameSr[FRAME_BITS-1];
  assign mdioOe = oeSr[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSr <= '1;
      oeSr    <= '0;
      capSr   <= '0;
      readQ   <= 1'b0;
      dataReg <= '0;
    end else begin
      if (strb.load) begin
        frameSr <= frameNew;
        oeSr    <= oeNew;
        readQ   <= loadRead;
      end else if (strb.shift) begin
        frameSr <= {frameSr[FRAME_BITS-2:0], 1'b1};
        oeSr    <= {oeSr[FRAME_BITS-2:0], 1'b0};
      end
      if (strb.sample) capSr <= {capSr[DATA_BITS-2:0], mdioI};
      if (strb.done) begin
        frameSr <= '1;
        oeSr    <= '0;
        if (readQ) dataReg <= {{(32 - DATA_BITS){1'b0}}, capSr};
      end
      if (dataWr) dataReg <= wrData;
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int              SYS_CLK_KHZ = 100000,
  parameter int              ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] ACC_OFS   = ADDR_W'(12'h120),
  parameter logic [ADDR_W-1:0] DATA_OFS  = ADDR_W'(12'h124)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWrEn,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [31:0]       csrWrData,
  output logic [31:0]       csrRdData,
  output logic              mdc,
  output logic              mdioO,
  output logic              mdioOe,
  input  logic              mdioI
);
  accFields_t       wrFields, fields;
  mdioStrobe_t      strb;
  logic             busy, isRead, accWr, dataWr;
  logic [IDX_W-1:0] bitIdx;
  logic [31:0]      dataReg;

  assign accWr  = csrWrEn && (csrAddr == ACC_OFS);
  assign dataWr = csrWrEn && (csrAddr == DATA_OFS) && !busy;

  assign wrFields = '{rate:  csrWrData[18:16], phy: csrWrData[15:11],
                      regad: csrWrData[10:6],  cl45: csrWrData[3],
                      cmd:   csrWrData[2:1]};

  always_comb begin
    if (csrAddr == ACC_OFS)
      csrRdData = {13'b0, fields.rate, fields.phy, fields.regad, 2'b00,
                   fields.cl45, fields.cmd, busy};
    else if (csrAddr == DATA_OFS)
      csrRdData = dataReg;
    else
      csrRdData = '0;
  end

  mdio_ctrl #(.SYS_CLK_KHZ(SYS_CLK_KHZ)) u_ctrl (
    .clk(clk), .rstN(rstN), .accWr(accWr), .wrGo(csrWrData[0]),
    .wrFields(wrFields), .busy(busy), .fields(fields), .strb(strb),
    .bitIdx(bitIdx), .isRead(isRead), .mdc(mdc)
  );

  mdio_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ldPhy(wrFields.phy), .ldReg(wrFields.regad),
    .ldCl45(wrFields.cl45), .ldCmd(wrFields.cmd),
    .dataWr(dataWr), .wrData(csrWrData), .mdioI(mdioI),
    .mdioO(mdioO), .mdioOe(mdioOe), .dataReg(dataReg)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             mdc,
  input logic             mdioO,
  input logic             mdioOe,
  input logic             busy,
  input accFields_t       fields,
  input logic             isRead,
  input logic [IDX_W-1:0] bitIdx
);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  assert_stable_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    mdc |-> ($stable(mdioO) && $stable(mdioOe)));

  assert_mdc_in_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> busy);

  assert_fields_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(fields));

  assert_read_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && isRead && (bitIdx >= IDX_W'(DRIVE_RD))) |-> !mdioOe);

  assert_write_drive_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !isRead) |-> mdioOe);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioO(mdioO), .mdioOe(mdioOe),
  .busy(busy), .fields(fields), .isRead(isRead), .bitIdx(bitIdx)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_ACC  = 12'h120;
  localparam logic [11:0] A_DATA = 12'h124;
  localparam logic [31:0] FMASK  = 32'h0007_FFCE;
  localparam int NVEC = 7;
  // {access word, data to write, PHY response, expected MDC period}
  localparam logic [71:0] VEC [NVEC] = '{
    {32'h0003_1A83, 16'hBEEF, 16'h0000, 8'd4},
    {32'h0002_F841, 16'h0000, 16'hA5C3, 8'd8},
    {32'h0001_11C9, 16'h1234, 16'h0000, 8'd20},
    {32'h0000_11CD, 16'h0000, 16'h5A0F, 8'd40},
    {32'h0003_8F8B, 16'h0F0F, 16'h0000, 8'd4},
    {32'h0004_40CF, 16'h0000, 16'hC001, 8'd80},
    {32'h0007_07C3, 16'h8001, 16'h0000, 8'd80}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [31:0] csrWrData = '0;
  logic [31:0] csrRdData;
  logic        mdc, mdioO, mdioOe;
  logic        mdioI = 1'b1;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int riseCnt = 0;
  int lastRise = 0;
  int period = 0;
  logic [63:0] txCap = '0;
  logic [63:0] oeCap = '0;
  logic [15:0] resp = '0;
  logic        mdcPrev = 1'b0;

  mdio_mgmt_ctrl u_dut (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrAddr(csrAddr),
    .csrWrData(csrWrData), .csrRdData(csrRdData), .mdc(mdc),
    .mdioO(mdioO), .mdioOe(mdioOe), .mdioI(mdioI)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // PHY side model, sampled away from the active edge
  always @(negedge clk) begin
    int pos;
    cyc = cyc + 1;
    if (mdc && !mdcPrev) begin
      pos = 63 - (riseCnt % 64);
      txCap[pos] = mdioO;
      oeCap[pos] = mdioOe;
      if ((riseCnt % 64) != 0) period = cyc - lastRise;
      lastRise = cyc;
      riseCnt = riseCnt + 1;
    end
    if (!mdc && mdcPrev) begin
      pos = riseCnt % 64;
      mdioI = (pos >= 48) ? resp[63 - pos] : 1'b1;
    end
    mdcPrev = mdc;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic csrWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csrAddr = a; csrWrData = d; csrWrEn = 1'b1;
    @(negedge clk);
    csrWrEn = 1'b0;
  endtask

  task automatic csrRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    csrAddr = a;
    #1 d = csrRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    int n = 0;
    do begin
      csrRead(A_ACC, v);
      n++;
    end while (v[0] && n < 20000);
    check(!v[0], "R2", "busy clears after frame", 64'(v[0]), 64'd0);
  endtask

  function automatic logic rdCmd(input logic [31:0] acc);
    return acc[3] ? acc[2] : !acc[1];
  endfunction

  function automatic logic [63:0] expFrame(input logic [31:0] acc, input logic [15:0] dat);
    logic [1:0] op;
    logic rd;
    rd = rdCmd(acc);
    if (acc[3]) op = (acc[2:1] == 2'b10) ? 2'b11 : (acc[2:1] == 2'b11) ? 2'b10 : acc[2:1];
    else        op = acc[1] ? 2'b01 : 2'b10;
    return {32'hFFFF_FFFF, acc[3] ? 2'b00 : 2'b01, op, acc[15:11], acc[10:6],
            rd ? 2'b00 : 2'b10, rd ? 16'h0000 : dat};
  endfunction

  function automatic logic [63:0] expOe(input logic [31:0] acc);
    return rdCmd(acc) ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, acc;
    logic [15:0] dat;
    logic [63:0] ef, eo;
    int per, r0;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    csrRead(A_ACC, v);  check(v == 0, "R1", "access after reset", 64'(v), 64'd0);
    csrRead(A_DATA, v); check(v == 0, "R1", "data after reset", 64'(v), 64'd0);
    check(mdc == 1'b0, "R9", "mdc idle after reset", 64'(mdc), 64'd0);
    check(mdioOe == 1'b0, "R9", "oe idle after reset", 64'(mdioOe), 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      acc = VEC[i][71:40]; dat = VEC[i][39:24];
      resp = VEC[i][23:8]; per = int'(VEC[i][7:0]);
      csrWrite(A_DATA, {16'h0000, dat});
      r0 = riseCnt;
      csrWrite(A_ACC, acc);
      csrRead(A_ACC, v);
      check(v[0] == 1'b1, "R2", "busy set after start", 64'(v[0]), 64'd1);
      waitIdle();
      ef = expFrame(acc, dat);
      eo = expOe(acc);
      check(riseCnt - r0 == 64, "R2", "one 64-bit frame", 64'(riseCnt - r0), 64'd64);
      check(oeCap == eo, rdCmd(acc) ? "R7" : "R6", "drive pattern", oeCap, eo);
      check(((txCap ^ ef) & eo) == 0, "R4", "frame bits", txCap & eo, ef & eo);
      check(txCap[29:28] == ef[29:28], "R5", "wire opcode", 64'(txCap[29:28]), 64'(ef[29:28]));
      check(period == per, "R8", "MDC period", 64'(period), 64'(per));
      csrRead(A_ACC, v);
      check(v == (acc & FMASK), "R1", "access readback", 64'(v), 64'(acc & FMASK));
      csrRead(A_DATA, v);
      if (rdCmd(acc))
        check(v == {16'h0, resp}, "R7", "read result", 64'(v), 64'({16'h0, resp}));
      else
        check(v == {16'h0, dat}, "R6", "data kept", 64'(v), 64'({16'h0, dat}));
      check(!mdc && !mdioOe, "R9", "idle pins", 64'({mdc, mdioOe}), 64'd0);
    end

    // unmapped offset
    csrRead(12'h128, v);
    check(v == 0, "R1", "unmapped read", 64'(v), 64'd0);

    // fields-only write, no frame
    r0 = riseCnt;
    csrWrite(A_ACC, 32'h0002_5A40);
    repeat (300) @(negedge clk);
    check(riseCnt == r0, "R2", "no frame without go bit", 64'(riseCnt - r0), 64'd0);
    csrRead(A_ACC, v);
    check(v == 32'h0002_5A40, "R2", "fields stored", 64'(v), 64'h0002_5A40);

    // writes during a frame are ignored
    resp = 16'h0000;
    csrWrite(A_DATA, 32'h0000_1111);
    r0 = riseCnt;
    csrWrite(A_ACC, 32'h0003_1A83);
    repeat (20) @(negedge clk);
    csrWrite(A_ACC, 32'h0000_F807);
    csrWrite(A_DATA, 32'h0000_2222);
    waitIdle();
    ef = expFrame(32'h0003_1A83, 16'h1111);
    check(txCap == ef, "R3", "frame unchanged by busy writes", txCap, ef);
    csrRead(A_DATA, v);
    check(v == 32'h1111, "R3", "data write ignored", 64'(v), 64'h1111);
    csrRead(A_ACC, v);
    check(v == 32'h0003_1A82, "R3", "access write ignored", 64'(v), 64'h0003_1A82);
    repeat (300) @(negedge clk);
    check(riseCnt - r0 == 64, "R3", "no second frame", 64'(riseCnt - r0), 64'd64);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule